// File: doc/BRIEF.md
# UART Receive Register Front End

This block is the register-mapped front end of a UART peripheral. A host reaches it through a simple word-wide register bus with address, write strobe, write data, read strobe and read data. On the line side it takes received bytes through a valid/ready byte port and sends transmitted bytes as a one-cycle pulse on a byte port. Serial bit timing is not part of this block. The clock divider, oversampling, pin, DMA and wake registers are only stored and read back.

Received bytes go into an 8-entry FIFO. A fill state machine tracks that FIFO. It has three states: FILL_EMPTY, FILL_PARTIAL and FILL_FULL. Its transitions are:
- fill-first: FILL_EMPTY to FILL_PARTIAL.
- top-off: FILL_PARTIAL to FILL_FULL.
- drain: FILL_PARTIAL to FILL_EMPTY.
- release: FILL_FULL to FILL_PARTIAL.
- flush: any state to FILL_EMPTY, or to FILL_PARTIAL when a byte arrives in the same cycle.

The host sets a receive threshold in the control word. Each accepted byte whose arrival brings the occupancy to or above that threshold raises a sticky flag. The flags are write-one-to-clear, and the interrupt output is the OR of the flags that are enabled.

Read data is combinational from the address while the read strobe is high. A read of the FIFO register pops the FIFO at the clock edge that ends the read.

Top module: `uart_rx_regif`

Register offsets:

| Offset | Register |
|---|---|
| 0x00 | control |
| 0x04 | status |
| 0x08 | interrupt enable |
| 0x0C | interrupt flags |
| 0x10 | clock divider |
| 0x14 | oversampling |
| 0x18 | peek |
| 0x1C | pin |
| 0x20 | FIFO |
| 0x30 | DMA |
| 0x34 | wake enable |
| 0x38 | wake flags |

## Requirements
- R1: The receive FIFO holds at most 8 bytes, and a byte offered while it is full is not accepted.
- R2: Control bits [3:0] hold the receive threshold. When a byte is accepted and the occupancy after that cycle is greater than or equal to the threshold, flag bit 4 is set. This bit stays set until it is cleared.
- R3: rx_ready is high only when control bit 15 (baud clock enable) is set and the FIFO is not full.
- R4: A control write with bit 15 set stores bit 19 (baud clock ready) as 1 in the same write.
- R5: Control bit 5 (receive flush) and control bit 6 (transmit flush) are never stored. A control write with bit 5 set empties the FIFO.
- R6: A write to the flag register at 0x0C clears each flag bit whose write-data bit is 1. irq is high whenever any bit of the flags ANDed with the enables at 0x08 is set.
- R7: A read of 0x20 returns the head byte and pops it, or returns 0 and pops nothing when the FIFO is empty. A read of 0x18 returns the head byte, or 0 when empty, without popping.
- R8: The status register at 0x04 reads as follows:
  - bits [11:8] hold the FIFO occupancy;
  - bit 6 always reads 1;
  - bit 4 reads 1 when the FIFO is empty;
  - writes to it are ignored.
- R9: A write to 0x20 gives a one-cycle tx_valid pulse in the next cycle, with tx_data equal to the low 8 bits of the write data, and it sets flag bit 6.
- R10: After reset, the registers hold these values:
  - control, enables, flags, clock divider, oversampling, DMA and wake registers are 0;
  - the pin register reads 0x2 (bit 1 is RTS);
  - the FIFO is empty;
  - irq and rx_ready are low.
- R11: The clock divider (0x10), oversampling (0x14), pin (0x1C), DMA (0x30), wake enable (0x34) and wake flag (0x38) registers read back the full 32-bit word last written.
- R12: Unmapped offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Byte is taken when rx_valid and rx_ready are both high |
| tx_valid | output | 1 | One-cycle pulse per transmitted byte |
| tx_data | output | 8 | Transmitted byte |
| irq | output | 1 | Interrupt request |

## Verification
The main function is exercised with several byte patterns:
- A threshold of 3 with bytes offered one by one. This separates the second byte, which must not set the flag, from the third, which must.
- A threshold of 0. This shows that the compare is greater-or-equal and fires on the first byte.
- Filling to eight and offering a ninth. This tells the full boundary apart from ordinary acceptance, since the ninth byte must not appear in the read order.
- Peek before pop, reads of an empty FIFO, and a flush with the baud clock enabled. These separate a non-destructive read from a popping read and from an emptied FIFO.

// File: rtl/uart_rx_regif_pkg.sv
package uart_rx_regif_pkg;

    localparam int REG_W  = 32;
    localparam int BYTE_W = 8;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_STATUS = 8'h04;
    localparam logic [7:0] OFS_INTEN  = 8'h08;
    localparam logic [7:0] OFS_INTFL  = 8'h0C;
    localparam logic [7:0] OFS_CLKDIV = 8'h10;
    localparam logic [7:0] OFS_OSR    = 8'h14;
    localparam logic [7:0] OFS_PEEK   = 8'h18;
    localparam logic [7:0] OFS_PIN    = 8'h1C;
    localparam logic [7:0] OFS_FIFO   = 8'h20;
    localparam logic [7:0] OFS_DMA    = 8'h30;
    localparam logic [7:0] OFS_WKEN   = 8'h34;
    localparam logic [7:0] OFS_WKFL   = 8'h38;

    localparam int CTL_THR_W    = 4;
    localparam int CTL_RXFLUSH  = 5;
    localparam int CTL_TXFLUSH  = 6;
    localparam int CTL_BCLKEN   = 15;
    localparam int CTL_BCLKRDY  = 19;
    localparam int FLG_RXTHD    = 4;
    localparam int FLG_TXHE     = 6;
    localparam int ST_RXEMPTY   = 4;
    localparam int ST_TXEMPTY   = 6;
    localparam int ST_LVL_LSB   = 8;
    localparam int PIN_RTS      = 1;

    typedef enum logic [1:0] {
        FILL_EMPTY,
        FILL_PARTIAL,
        FILL_FULL
    } fill_state_t;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_inten;
        logic wr_intfl;
        logic wr_clkdiv;
        logic wr_osr;
        logic wr_pin;
        logic wr_fifo;
        logic wr_dma;
        logic wr_wken;
        logic wr_wkfl;
        logic rd_fifo;
    } reg_strobe_t;

endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_regif_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  count_next,
    output logic              full,
    output logic              empty,
    output fill_state_t       state
);

    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr_q, rptr_q, wbase, rbase;
    logic [CNT_W-1:0]  cnt_q, cnt_base;
    logic              pop_ok;
    fill_state_t       state_q, state_d;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        pop_ok     = pop_req && (state_q != FILL_EMPTY) && !flush;
        wbase      = flush ? '0 : wptr_q;
        rbase      = flush ? '0 : rptr_q;
        cnt_base   = flush ? '0 : cnt_q;
        count_next = cnt_base + CNT_W'(push) - CNT_W'(pop_ok);
    end

    // fill state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_EMPTY: begin
                if (count_next == CNT_MAX)   state_d = FILL_FULL;
                else if (count_next != '0)   state_d = FILL_PARTIAL;
            end
            FILL_PARTIAL: begin
                if (count_next == '0)        state_d = FILL_EMPTY;
                else if (count_next == CNT_MAX) state_d = FILL_FULL;
            end
            FILL_FULL: begin
                if (count_next == '0)        state_d = FILL_EMPTY;
                else if (count_next != CNT_MAX) state_d = FILL_PARTIAL;
            end
            default: state_d = FILL_EMPTY;
        endcase
    end

    // fill state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FILL_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            wptr_q <= push   ? ptr_inc(wbase) : wbase;
            rptr_q <= pop_ok ? ptr_inc(rbase) : rbase;
            cnt_q  <= count_next;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wbase] <= push_data;
    end

    // fill state machine: outputs
    always_comb begin
        state = state_q;
        full  = (state_q == FILL_FULL);
        empty = (state_q == FILL_EMPTY);
        head  = mem[rptr_q];
        count = cnt_q;
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_rx_regif_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_wr,
    input  logic         fl_wr,
    input  logic [W-1:0] wdata,
    input  logic         set_rxthd,
    input  logic         set_txhe,
    output logic [W-1:0] int_en,
    output logic [W-1:0] int_fl,
    output logic         irq
);

    logic [W-1:0] en_q, fl_q, fl_d;

    always_comb begin
        fl_d = fl_q;
        if (fl_wr)     fl_d = fl_d & ~wdata;
        if (set_rxthd) fl_d[FLG_RXTHD] = 1'b1;
        if (set_txhe)  fl_d[FLG_TXHE]  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
            fl_q <= '0;
        end else begin
            if (en_wr) en_q <= wdata;
            fl_q <= fl_d;
        end
    end

    assign int_en = en_q;
    assign int_fl = fl_q;
    assign irq    = |(fl_q & en_q);

endmodule

// File: rtl/uart_reg_file.sv
module uart_reg_file
    import uart_rx_regif_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_head,
    input  logic [REG_W-1:0]  int_en,
    input  logic [REG_W-1:0]  int_fl,
    output reg_strobe_t       stb,
    output logic              rx_flush,
    output logic [REG_W-1:0]  ctrl,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data
);

    logic [REG_W-1:0]  ctrl_q, clkdiv_q, osr_q, pin_q, dma_q, wken_q, wkfl_q, ctrl_d;
    logic [BYTE_W-1:0] tx_q;
    logic              txv_q;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    always_comb begin
        stb.wr_ctrl   = bus_wr && hit(bus_addr, OFS_CTRL);
        stb.wr_inten  = bus_wr && hit(bus_addr, OFS_INTEN);
        stb.wr_intfl  = bus_wr && hit(bus_addr, OFS_INTFL);
        stb.wr_clkdiv = bus_wr && hit(bus_addr, OFS_CLKDIV);
        stb.wr_osr    = bus_wr && hit(bus_addr, OFS_OSR);
        stb.wr_pin    = bus_wr && hit(bus_addr, OFS_PIN);
        stb.wr_fifo   = bus_wr && hit(bus_addr, OFS_FIFO);
        stb.wr_dma    = bus_wr && hit(bus_addr, OFS_DMA);
        stb.wr_wken   = bus_wr && hit(bus_addr, OFS_WKEN);
        stb.wr_wkfl   = bus_wr && hit(bus_addr, OFS_WKFL);
        stb.rd_fifo   = bus_rd && hit(bus_addr, OFS_FIFO);
        rx_flush      = stb.wr_ctrl && bus_wdata[CTL_RXFLUSH];
        ctrl_d        = bus_wdata;
        if (bus_wdata[CTL_BCLKEN]) ctrl_d[CTL_BCLKRDY] = 1'b1;
        ctrl_d[CTL_RXFLUSH] = 1'b0;
        ctrl_d[CTL_TXFLUSH] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            clkdiv_q <= '0;
            osr_q    <= '0;
            pin_q    <= REG_W'(1) << PIN_RTS;
            dma_q    <= '0;
            wken_q   <= '0;
            wkfl_q   <= '0;
            tx_q     <= '0;
            txv_q    <= 1'b0;
        end else begin
            if (stb.wr_ctrl)   ctrl_q   <= ctrl_d;
            if (stb.wr_clkdiv) clkdiv_q <= bus_wdata;
            if (stb.wr_osr)    osr_q    <= bus_wdata;
            if (stb.wr_pin)    pin_q    <= bus_wdata;
            if (stb.wr_dma)    dma_q    <= bus_wdata;
            if (stb.wr_wken)   wken_q   <= bus_wdata;
            if (stb.wr_wkfl)   wkfl_q   <= bus_wdata;
            txv_q <= stb.wr_fifo;
            if (stb.wr_fifo)   tx_q     <= bus_wdata[BYTE_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if      (hit(bus_addr, OFS_CTRL))   bus_rdata = ctrl_q;
            else if (hit(bus_addr, OFS_STATUS)) begin
                bus_rdata[ST_LVL_LSB +: CNT_W] = fifo_count;
                bus_rdata[ST_TXEMPTY]          = 1'b1;
                bus_rdata[ST_RXEMPTY]          = fifo_empty;
            end
            else if (hit(bus_addr, OFS_INTEN))  bus_rdata = int_en;
            else if (hit(bus_addr, OFS_INTFL))  bus_rdata = int_fl;
            else if (hit(bus_addr, OFS_CLKDIV)) bus_rdata = clkdiv_q;
            else if (hit(bus_addr, OFS_OSR))    bus_rdata = osr_q;
            else if (hit(bus_addr, OFS_PIN))    bus_rdata = pin_q;
            else if (hit(bus_addr, OFS_DMA))    bus_rdata = dma_q;
            else if (hit(bus_addr, OFS_WKEN))   bus_rdata = wken_q;
            else if (hit(bus_addr, OFS_WKFL))   bus_rdata = wkfl_q;
            else if (hit(bus_addr, OFS_PEEK) || hit(bus_addr, OFS_FIFO))
                bus_rdata[BYTE_W-1:0] = fifo_empty ? '0 : fifo_head;
        end
    end

    assign ctrl     = ctrl_q;
    assign tx_valid = txv_q;
    assign tx_data  = tx_q;

endmodule

// File: rtl/uart_rx_regif.sv
module uart_rx_regif
    import uart_rx_regif_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq
);

    reg_strobe_t       stb;
    logic              rx_flush, fifo_full, fifo_empty, push, thr_hit;
    logic [REG_W-1:0]  ctrl_q, int_en, int_fl;
    logic [CNT_W-1:0]  fifo_count, fifo_count_nxt;
    logic [BYTE_W-1:0] fifo_head;
    fill_state_t       fill_state;

    assign rx_ready = ctrl_q[CTL_BCLKEN] && !fifo_full;
    assign push     = rx_valid && rx_ready;
    assign thr_hit  = push && (fifo_count_nxt >= CNT_W'(ctrl_q[CTL_THR_W-1:0]));

    uart_reg_file #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .fifo_count (fifo_count),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .int_en     (int_en),
        .int_fl     (int_fl),
        .stb        (stb),
        .rx_flush   (rx_flush),
        .ctrl       (ctrl_q),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data)
    );

    uart_rx_fifo #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (rx_flush),
        .push       (push),
        .push_data  (rx_data),
        .pop_req    (stb.rd_fifo),
        .head       (fifo_head),
        .count      (fifo_count),
        .count_next (fifo_count_nxt),
        .full       (fifo_full),
        .empty      (fifo_empty),
        .state      (fill_state)
    );

    uart_irq_ctrl #(.W(REG_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_wr     (stb.wr_inten),
        .fl_wr     (stb.wr_intfl),
        .wdata     (bus_wdata),
        .set_rxthd (thr_hit),
        .set_txhe  (stb.wr_fifo),
        .int_en    (int_en),
        .int_fl    (int_fl),
        .irq       (irq)
    );

endmodule

// File: rtl/uart_rx_regif_chk.sv
module uart_rx_regif_chk
    import uart_rx_regif_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              bus_rd,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [BYTE_W-1:0] tx_data,
    input logic [REG_W-1:0]  ctrl_q,
    input logic [REG_W-1:0]  int_fl,
    input logic [CNT_W-1:0]  fifo_count,
    input fill_state_t       fill_state
);

    logic at_ctrl, at_fifo, at_intfl, at_status;
    assign at_ctrl   = bus_addr == ADDR_W'(OFS_CTRL);
    assign at_fifo   = bus_addr == ADDR_W'(OFS_FIFO);
    assign at_intfl  = bus_addr == ADDR_W'(OFS_INTFL);
    assign at_status = bus_addr == ADDR_W'(OFS_STATUS);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH)); // R1
    AST_FILL_STATE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_state == FILL_EMPTY) == (fifo_count == '0)); // R1
    AST_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (ctrl_q[CTL_BCLKEN] && fifo_count < CNT_W'(DEPTH))); // R3
    AST_BCLK_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_ctrl && bus_wdata[CTL_BCLKEN]) |=> ctrl_q[CTL_BCLKRDY]); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_ctrl && bus_wdata[CTL_RXFLUSH] && !(rx_valid && rx_ready))
        |=> fifo_count == '0); // R5
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_intfl && bus_wdata[FLG_TXHE]) |=> !int_fl[FLG_TXHE]); // R6
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_fifo && fifo_count == '0) |-> bus_rdata == '0); // R7
    AST_STATUS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_status) |-> (bus_rdata[ST_RXEMPTY] == (fifo_count == '0))); // R8
    AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_fifo) |=> (tx_valid && tx_data == $past(bus_wdata[BYTE_W-1:0])
                                 && int_fl[FLG_TXHE])); // R9

endmodule

bind uart_rx_regif uart_rx_regif_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .ctrl_q     (ctrl_q),
    .int_fl     (int_fl),
    .fifo_count (fifo_count),
    .fill_state (fill_state)
);

// File: tb/uart_rx_regif_tb.sv
module uart_rx_regif_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uart_rx_regif u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, output logic took);
        @(negedge clk);
        rx_data = b; rx_valid = 1'b1;
        #1 took = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); chk("R10 ctrl", v, 32'h0);
        rd(8'h04, v); chk("R10 status", v, 32'h50);
        rd(8'h08, v); chk("R10 inten", v, 32'h0);
        rd(8'h0C, v); chk("R10 flags", v, 32'h0);
        rd(8'h1C, v); chk("R10 pin", v, 32'h2);
        rd(8'h10, v); chk("R10 clkdiv", v, 32'h0);
        chk("R10 irq", {31'b0, irq}, 32'h0);
        chk("R10 rx_ready", {31'b0, rx_ready}, 32'h0);
    endtask

    task automatic t_gate();
        logic took; logic [31:0] v;
        push(8'h11, took);
        chk("R3 ready low when disabled", {31'b0, took}, 32'h0);
        rd(8'h04, v); chk("R3 nothing stored", v, 32'h50);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(8'h00, 32'h0000_8063);
        rd(8'h00, v); chk("R4 R5 ctrl stored", v, 32'h0008_8003);
        chk("R3 ready when enabled", {31'b0, rx_ready}, 32'h1);
    endtask

    task automatic t_threshold();
        logic took; logic [31:0] v;
        push(8'hA1, took); push(8'hA2, took);
        rd(8'h0C, v); chk("R2 below threshold", v, 32'h0);
        push(8'hA3, took);
        rd(8'h0C, v); chk("R2 threshold reached", v, 32'h10);
        rd(8'h04, v); chk("R8 level three", v, 32'h340);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        chk("R6 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h08, 32'h10);
        chk("R6 irq enabled", {31'b0, irq}, 32'h1);
        wr(8'h0C, 32'h0);
        rd(8'h0C, v); chk("R6 zero write keeps flag", v, 32'h10);
        wr(8'h0C, 32'h10);
        rd(8'h0C, v); chk("R6 w1c", v, 32'h0);
        chk("R6 irq cleared", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_peek_pop();
        logic [31:0] v;
        rd(8'h18, v); chk("R7 peek", v, 32'hA1);
        rd(8'h18, v); chk("R7 peek again", v, 32'hA1);
        rd(8'h04, v); chk("R7 peek keeps level", v, 32'h340);
        rd(8'h20, v); chk("R7 pop 1", v, 32'hA1);
        rd(8'h20, v); chk("R7 pop 2", v, 32'hA2);
        rd(8'h20, v); chk("R7 pop 3", v, 32'hA3);
        rd(8'h20, v); chk("R7 empty pop", v, 32'h0);
        rd(8'h18, v); chk("R7 empty peek", v, 32'h0);
        rd(8'h04, v); chk("R8 empty again", v, 32'h50);
    endtask

    task automatic t_full();
        logic took; logic [31:0] v;
        for (int i = 0; i < 8; i++) push(8'h30 + 8'(i), took);
        chk("R3 not ready when full", {31'b0, rx_ready}, 32'h0);
        push(8'hEE, took);
        chk("R1 ninth rejected", {31'b0, took}, 32'h0);
        rd(8'h04, v); chk("R1 R8 level eight", v, 32'h840);
        rd(8'h20, v); chk("R1 head order", v, 32'h30);
        push(8'h77, took);
        chk("R1 accepted after pop", {31'b0, took}, 32'h1);
        for (int i = 1; i < 8; i++) begin
            rd(8'h20, v); chk("R1 drain order", v, 32'h30 + i);
        end
        rd(8'h20, v); chk("R1 ninth slot byte", v, 32'h77);
    endtask

    task automatic t_flush();
        logic took; logic [31:0] v;
        push(8'h55, took); push(8'h56, took);
        wr(8'h00, 32'h0000_8023);
        rd(8'h04, v); chk("R5 flush empties", v, 32'h50);
        rd(8'h00, v); chk("R5 flush bit not stored", v, 32'h0008_8003);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h08, 32'h40);
        @(negedge clk);
        bus_addr = 8'h20; bus_wdata = 32'h1234_56C3; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R9 tx_valid", {31'b0, tx_valid}, 32'h1);
        chk("R9 tx_data", {24'b0, tx_data}, 32'hC3);
        chk("R9 R6 irq", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R9 single pulse", {31'b0, tx_valid}, 32'h0);
        rd(8'h0C, v); chk("R9 flag", v, 32'h40);
        rd(8'h04, v); chk("R9 no rx effect", v, 32'h50);
    endtask

    task automatic t_store();
        logic [31:0] v;
        wr(8'h10, 32'hDEAD_0001); rd(8'h10, v); chk("R11 clkdiv", v, 32'hDEAD_0001);
        wr(8'h14, 32'h0000_00A5); rd(8'h14, v); chk("R11 osr", v, 32'hA5);
        wr(8'h1C, 32'h0000_0001); rd(8'h1C, v); chk("R11 pin", v, 32'h1);
        wr(8'h30, 32'hCAFE_F00D); rd(8'h30, v); chk("R11 dma", v, 32'hCAFE_F00D);
        wr(8'h34, 32'h8000_0000); rd(8'h34, v); chk("R11 wken", v, 32'h8000_0000);
        wr(8'h38, 32'h0F0F_0F0F); rd(8'h38, v); chk("R11 wkfl", v, 32'h0F0F_0F0F);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, v); chk("R12 unmapped read", v, 32'h0);
        rd(8'h00, v); chk("R12 ctrl untouched", v, 32'h0008_8003);
        rd(8'h10, v); chk("R12 clkdiv untouched", v, 32'hDEAD_0001);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R8 status write ignored", v, 32'h50);
    endtask

    task automatic t_thr_zero();
        logic took; logic [31:0] v;
        wr(8'h00, 32'h0000_8000);
        wr(8'h0C, 32'hFFFF_FFFF);
        push(8'h99, took);
        rd(8'h0C, v); chk("R2 threshold zero", v, 32'h10);
        rd(8'h00, v); chk("R4 ready bit", v, 32'h0008_8000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gate();
        t_ctrl();
        t_threshold();
        t_irq();
        t_peek_pop();
        t_full();
        t_flush();
        t_tx();
        t_store();
        t_unmapped();
        t_thr_zero();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule